// File: doc/BRIEF.md
# Smart Card Interface Command Slave

This block is the host-side serial front end of a smart card interface. It is a slave on a two-wire bus: an open-collector clock and an open-drain data line. The host uses it to give commands to the card interface logic and to read back status. Both lines are oversampled by the system clock. The block drives the data line only through an output enable, which pulls the line low when set.

The 7-bit bus address has two parts. The upper part is a fixed parameter. The low part is sampled from three shared pins after every reset: the hardware reset, a soft-reset command, or a general-call reset. Once the address is latched, those pins can carry other signals. This lets up to eight devices share one bus.

A write frame carries three kinds of byte in order: the address byte, one command byte, and then data bytes. The command byte decides which register group receives the data bytes. The block reports each accepted byte on a one-cycle write strobe, together with the data and an index within the group. A read frame carries the address byte and then status bytes returned by the device, with no command byte.

Top module: `twc_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and no strobe (`cfg_we`, `tmr_we`, `ifc_we`, `soft_rst`) is asserted.
- R2: The device answers the address `{ADDR_HI, addr_pins}` as sampled after the most recent reset. Changing `addr_pins` later has no effect on the address.
- R3: An address byte equal to the device address shifted left (bit 0 = direction, 1 = read) is acknowledged. Any other address except general call is not acknowledged, and the data line stays released.
- R4: A command byte with bit 7 = 1 is the interface write. It gives exactly one `ifc_we` pulse, with `wr_data = {1'b0, cmd[6:0]}`. Data bytes that follow it are acknowledged but cause no strobe.
- R5: A command byte with bit 7 = 0 selects a group by its bits [1:0]: 01 for config and 10 for timer. Each following data byte gives one pulse of `cfg_we` or `tmr_we` with `wr_data` set to the byte and `wr_idx` counting up from 0. Code 11 selects nothing, so its data is acknowledged and dropped. Strobes are mutually exclusive.
- R6: A command byte with bit 7 = 0 and bits [1:0] = 00 is the reset command. It gives one `soft_rst` pulse and re-samples `addr_pins` into the address.
- R7: The general-call address (byte 00h) is acknowledged. A following byte 06h is acknowledged and acts exactly like R6. Any other byte after a general call is not acknowledged and has no effect.
- R8: In a read frame the device sends status byte 0 first, most significant bit first. Status byte k is `stat_i[8k+7:8k]`. The byte index advances on each master ACK and wraps after `NUM_STAT` bytes. It restarts at 0 in every read frame. A master NACK ends the read, and the line is released.
- R9: A START seen in any state, including a repeated START inside a frame, aborts the frame and restarts address decoding. A STOP returns the block to idle, and the line is released.
- R10: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pins | input | LO_W | Shared pins giving the low address bits |
| stat_i | input | NUM_STAT*8 | Status bytes returned on reads, byte 0 in the low bits |
| sda_oe | output | 1 | Pull the data line low when 1 |
| cfg_we | output | 1 | Config group write strobe |
| tmr_we | output | 1 | Timer group write strobe |
| ifc_we | output | 1 | Interface write strobe |
| soft_rst | output | 1 | Soft reset pulse |
| wr_data | output | 8 | Data for the strobe that is asserted |
| wr_idx | output | WIDX_W | Byte index within the group for config and timer writes |

## Verification
The bench builds the block with `ADDR_HI` = 11 (binary 1011), `LO_W` = 3 and `WIDX_W` = 3, and sets `NUM_STAT` to 3 rather than the default. A four-byte read therefore crosses the index wrap and returns byte 0 again. Moving the address pins between 010 and 111 lets the bench check both sides of the re-latch. The old address must keep answering until a soft or general-call reset, and only the new one answers after it.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKD, ST_TX, ST_MACK, ST_MLOAD
  } st_e;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_DATA, K_GC
  } kind_e;

  typedef enum logic [1:0] {
    G_IGN, G_CFG, G_TMR
  } grp_e;

  localparam logic [1:0] CMD_RST = 2'b00;
  localparam logic [1:0] CMD_CFG = 2'b01;
  localparam logic [1:0] CMD_TMR = 2'b10;
  localparam logic [7:0] GC_RESET = 8'h06;
endpackage

// File: rtl/twc_line_mon.sv
module twc_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_s1, scl_s2, scl_p;
  logic sda_s1, sda_s2, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s1 <= 1'b1; scl_s2 <= 1'b1; scl_p <= 1'b1;
      sda_s1 <= 1'b1; sda_s2 <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s1 <= scl_i; scl_s2 <= scl_s1; scl_p <= scl_s2;
      sda_s1 <= sda_i; sda_s2 <= sda_s1; sda_p <= sda_s2;
    end
  end

  assign sda_q    = sda_s2;
  assign scl_rise = scl_s2 & ~scl_p;
  assign scl_fall = ~scl_s2 & scl_p;
  assign start_ev = scl_s2 & scl_p & sda_p & ~sda_s2;
  assign stop_ev  = scl_s2 & scl_p & ~sda_p & sda_s2;
endmodule

// File: rtl/twc_addr_latch.sv
module twc_addr_latch #(
  parameter int unsigned LO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            relatch,
  input  logic [LO_W-1:0] pins,
  output logic [LO_W-1:0] addr_lo
);
  logic            pend_q, pend_d;
  logic [LO_W-1:0] lo_q, lo_d;

  always_comb begin
    pend_d = pend_q;
    lo_d   = lo_q;
    if (pend_q) begin
      lo_d   = pins;
      pend_d = 1'b0;
    end
    if (relatch) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      lo_q   <= '0;
    end else begin
      pend_q <= pend_d;
      lo_q   <= lo_d;
    end
  end

  assign addr_lo = lo_q;
endmodule

// File: rtl/twc_frame_fsm.sv
module twc_frame_fsm
  import twc_pkg::*;
#(
  parameter int unsigned NUM_STAT = 4,
  parameter int unsigned WIDX_W   = 3,
  localparam int unsigned IW = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_q,
  input  logic [6:0]        my_addr,
  input  logic [7:0]        cur_byte,
  output logic [IW-1:0]     rd_idx,
  output logic              sda_oe,
  output logic              cfg_we,
  output logic              tmr_we,
  output logic              ifc_we,
  output logic              soft_rst,
  output logic [7:0]        wr_data,
  output logic [WIDX_W-1:0] wr_idx
);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_STAT - 1);

  st_e              st_q, st_d;
  kind_e            kind_q, kind_d;
  grp_e             grp_q, grp_d;
  logic [3:0]       bc_q, bc_d;
  logic [7:0]       sh_q, sh_d;
  logic             tx_q, tx_d;
  logic [IW-1:0]    ri_q, ri_d;
  logic [WIDX_W-1:0] wi_q, wi_d;
  logic             oe_q, oe_d;
  logic             cfg_q, cfg_d, tmr_q, tmr_d, ifc_q, ifc_d, srst_q, srst_d;
  logic [7:0]       wd_q, wd_d;
  logic [WIDX_W-1:0] wo_q, wo_d;

  always_comb begin
    st_d = st_q; kind_d = kind_q; grp_d = grp_q; bc_d = bc_q; sh_d = sh_q;
    tx_d = tx_q; ri_d = ri_q; wi_d = wi_q; oe_d = oe_q;
    wd_d = wd_q; wo_d = wo_q;
    cfg_d = 1'b0; tmr_d = 1'b0; ifc_d = 1'b0; srst_d = 1'b0;

    if (stop_ev) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_ev) begin
      st_d = ST_RX; kind_d = K_ADDR; bc_d = '0; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && bc_q != 4'd8) begin
            sh_d = {sh_q[6:0], sda_q};
            bc_d = bc_q + 4'd1;
          end
          if (scl_fall && bc_q == 4'd8) begin
            st_d = ST_ACKD; oe_d = 1'b1; tx_d = 1'b0;
            unique case (kind_q)
              K_ADDR: begin
                if (sh_q[7:1] == my_addr) begin
                  tx_d = sh_q[0]; ri_d = '0; kind_d = K_CMD;
                end else if (sh_q == 8'h00) begin
                  kind_d = K_GC;
                end else begin
                  st_d = ST_IDLE; oe_d = 1'b0;
                end
              end
              K_CMD: begin
                kind_d = K_DATA; wi_d = '0; grp_d = G_IGN;
                if (sh_q[7]) begin
                  ifc_d = 1'b1; wd_d = {1'b0, sh_q[6:0]};
                end else begin
                  unique case (sh_q[1:0])
                    CMD_RST: srst_d = 1'b1;
                    CMD_CFG: grp_d = G_CFG;
                    CMD_TMR: grp_d = G_TMR;
                    default: grp_d = G_IGN;
                  endcase
                end
              end
              K_DATA: begin
                if (grp_q != G_IGN) begin
                  cfg_d = (grp_q == G_CFG);
                  tmr_d = (grp_q == G_TMR);
                  wd_d  = sh_q; wo_d = wi_q; wi_d = wi_q + 1'b1;
                end
              end
              default: begin
                if (sh_q == GC_RESET) begin
                  srst_d = 1'b1; kind_d = K_DATA; grp_d = G_IGN;
                end else begin
                  st_d = ST_IDLE; oe_d = 1'b0;
                end
              end
            endcase
          end
        end
        ST_ACKD: if (scl_fall) begin
          if (tx_q) begin
            sh_d = cur_byte; oe_d = ~cur_byte[7]; bc_d = '0; st_d = ST_TX;
          end else begin
            oe_d = 1'b0; bc_d = '0; st_d = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) bc_d = bc_q + 4'd1;
          if (scl_fall) begin
            if (bc_q == 4'd8) begin
              oe_d = 1'b0; st_d = ST_MACK;
            end else if (bc_q != 4'd0) begin
              sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
            end
          end
        end
        ST_MACK: if (scl_rise) begin
          if (!sda_q) begin
            ri_d = (ri_q == IDX_LAST) ? '0 : ri_q + 1'b1;
            st_d = ST_MLOAD;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_MLOAD: if (scl_fall) begin
          sh_d = cur_byte; oe_d = ~cur_byte[7]; bc_d = '0; st_d = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; kind_q <= K_ADDR; grp_q <= G_IGN; bc_q <= '0;
      sh_q <= '0; tx_q <= 1'b0; ri_q <= '0; wi_q <= '0; oe_q <= 1'b0;
      cfg_q <= 1'b0; tmr_q <= 1'b0; ifc_q <= 1'b0; srst_q <= 1'b0;
      wd_q <= '0; wo_q <= '0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; grp_q <= grp_d; bc_q <= bc_d;
      sh_q <= sh_d; tx_q <= tx_d; ri_q <= ri_d; wi_q <= wi_d; oe_q <= oe_d;
      cfg_q <= cfg_d; tmr_q <= tmr_d; ifc_q <= ifc_d; srst_q <= srst_d;
      wd_q <= wd_d; wo_q <= wo_d;
    end
  end

  assign rd_idx   = ri_q;
  assign sda_oe   = oe_q;
  assign cfg_we   = cfg_q;
  assign tmr_we   = tmr_q;
  assign ifc_we   = ifc_q;
  assign soft_rst = srst_q;
  assign wr_data  = wd_q;
  assign wr_idx   = wo_q;
endmodule

// File: rtl/twc_slave.sv
module twc_slave #(
  parameter int unsigned ADDR_HI  = 11,
  parameter int unsigned LO_W     = 3,
  parameter int unsigned NUM_STAT = 4,
  parameter int unsigned WIDX_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [LO_W-1:0]       addr_pins,
  input  logic [NUM_STAT*8-1:0] stat_i,
  output logic                  sda_oe,
  output logic                  cfg_we,
  output logic                  tmr_we,
  output logic                  ifc_we,
  output logic                  soft_rst,
  output logic [7:0]            wr_data,
  output logic [WIDX_W-1:0]     wr_idx
);
  localparam int unsigned HI_W = 7 - LO_W;
  localparam int unsigned IW   = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1;

  logic            sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  logic [LO_W-1:0] addr_lo;
  logic [IW-1:0]   rd_idx;
  logic [7:0]      cur_byte;

  twc_line_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twc_addr_latch #(.LO_W(LO_W)) u_alat (
    .clk(clk), .rst_n(rst_n), .relatch(soft_rst),
    .pins(addr_pins), .addr_lo(addr_lo)
  );

  assign cur_byte = stat_i[{rd_idx, 3'b000} +: 8];

  twc_frame_fsm #(.NUM_STAT(NUM_STAT), .WIDX_W(WIDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_q(sda_q),
    .my_addr({HI_W'(ADDR_HI), addr_lo}), .cur_byte(cur_byte),
    .rd_idx(rd_idx), .sda_oe(sda_oe), .cfg_we(cfg_we), .tmr_we(tmr_we),
    .ifc_we(ifc_we), .soft_rst(soft_rst), .wr_data(wr_data), .wr_idx(wr_idx)
  );
endmodule

// File: rtl/twc_slave_chk.sv
module twc_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic cfg_we,
  input logic tmr_we,
  input logic ifc_we,
  input logic soft_rst,
  input logic start_ev,
  input logic stop_ev
);
  // R10: the data enable only moves while the clock line is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R5: at most one strobe at a time
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_we, tmr_we, ifc_we, soft_rst}));

  // R4: one interface byte gives a single-cycle pulse
  p_ifc_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_we |=> !ifc_we);

  // R6: the soft reset is a single-cycle pulse
  p_srst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  // R9: STOP releases the data line
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R9: START releases the data line
  p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
endmodule

bind twc_slave twc_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_we(cfg_we), .tmr_we(tmr_we), .ifc_we(ifc_we), .soft_rst(soft_rst),
  .start_ev(start_ev), .stop_ev(stop_ev)
);

// File: tb/twc_slave_bench.sv
`timescale 1ns/1ps
module twc_slave_bench;
  localparam int NS = 3;
  localparam int H  = 16;
  localparam logic [7:0] AW_OLD = 8'hB4;  // {1011,010,0}
  localparam logic [7:0] AR_OLD = 8'hB5;
  localparam logic [7:0] AW_NEW = 8'hBE;  // {1011,111,0}

  // cmd, data, expected group (0 none,1 cfg,2 tmr,3 ifc), expected wr_data
  localparam logic [25:0] VEC [7] = '{
    {8'h01, 8'h5C, 2'd1, 8'h5C},
    {8'h02, 8'hE7, 2'd2, 8'hE7},
    {8'h81, 8'h33, 2'd3, 8'h01},
    {8'hFD, 8'h44, 2'd3, 8'h7D},
    {8'h03, 8'h44, 2'd0, 8'h00},
    {8'h7D, 8'h12, 2'd1, 8'h12},
    {8'h7E, 8'h9A, 2'd2, 8'h9A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] pins = 3'b010;
  logic [NS*8-1:0] stat = {8'h3C, 8'hA5, 8'h96};
  logic sda_oe, cfg_we, tmr_we, ifc_we, soft_rst;
  logic [7:0] wr_data;
  logic [2:0] wr_idx;
  logic sda_bus;
  int n_chk = 0, n_fail = 0;
  int c_cfg = 0, c_tmr = 0, c_ifc = 0, c_rst = 0;
  logic [7:0] l_data = '0;
  logic [2:0] l_idx = '0;
  logic any_oe;
  bit done = 0;

  assign sda_bus = m_sda & ~sda_oe;
  always #4 clk = ~clk;

  twc_slave #(.ADDR_HI(11), .LO_W(3), .NUM_STAT(NS), .WIDX_W(3)) u_twc_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_pins(pins), .stat_i(stat), .sda_oe(sda_oe), .cfg_we(cfg_we),
    .tmr_we(tmr_we), .ifc_we(ifc_we), .soft_rst(soft_rst),
    .wr_data(wr_data), .wr_idx(wr_idx)
  );

  always @(negedge clk) begin
    if (cfg_we) begin c_cfg++; l_data = wr_data; l_idx = wr_idx; end
    if (tmr_we) begin c_tmr++; l_data = wr_data; l_idx = wr_idx; end
    if (ifc_we) begin c_ifc++; l_data = wr_data; end
    if (soft_rst) c_rst++;
    if (sda_oe) any_oe = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart;
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H); m_scl = 1'b0; hw(H);
  endtask

  task automatic bstop;
    m_sda = 1'b0; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b1; hw(H);
  endtask

  task automatic sendb(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0;
    end
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H/2);
    ack = (sda_bus == 1'b0);
    hw(H/2); m_scl = 1'b0; hw(H);
  endtask

  task automatic recvb(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H); m_scl = 1'b1; hw(H/2); b[i] = sda_bus; hw(H/2); m_scl = 1'b0;
    end
    m_sda = ~mack; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0; m_sda = 1'b1;
  endtask

  // Write frame: address, command, one data byte; returns all-ack flag
  task automatic wframe(input logic [7:0] a, input logic [7:0] c,
                        input logic [7:0] d, output bit ok);
    bit k1, k2, k3;
    bstart; sendb(a, k1); sendb(c, k2); sendb(d, k3); bstop;
    ok = k1 & k2 & k3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok, ak;
    logic [7:0] rb;
    int s0, s1, s2, s3;
    hw(5);
    // R1: reset state
    chk(sda_oe == 0 && !cfg_we && !tmr_we && !ifc_we && !soft_rst, "R1 reset", sda_oe, 0);
    rst_n = 1'b1; hw(10);
    chk(sda_oe == 0 && c_cfg + c_tmr + c_ifc + c_rst == 0, "R1 after release", sda_oe, 0);

    // R4 R5: command table
    for (int v = 0; v < 7; v++) begin
      s0 = c_cfg; s1 = c_tmr; s2 = c_ifc; s3 = c_rst;
      wframe(AW_OLD, VEC[v][25:18], VEC[v][17:10], ok);
      case (VEC[v][9:8])
        2'd1: chk(ok && c_cfg == s0+1 && c_tmr == s1 && c_ifc == s2 && l_data == VEC[v][7:0],
                  "R5 cfg vector", l_data, VEC[v][7:0]);
        2'd2: chk(ok && c_tmr == s1+1 && c_cfg == s0 && c_ifc == s2 && l_data == VEC[v][7:0],
                  "R5 tmr vector", l_data, VEC[v][7:0]);
        2'd3: chk(ok && c_ifc == s2+1 && c_cfg == s0 && c_tmr == s1 && l_data == VEC[v][7:0],
                  "R4 ifc vector", l_data, VEC[v][7:0]);
        default: chk(ok && c_cfg == s0 && c_tmr == s1 && c_ifc == s2 && c_rst == s3,
                  "R5 ignored group", c_cfg + c_tmr + c_ifc, s0 + s1 + s2);
      endcase
    end

    // R5: multi-byte config, index counts from 0
    s0 = c_cfg;
    bstart; sendb(AW_OLD, ak); sendb(8'h01, ak);
    sendb(8'h11, ak); sendb(8'h22, ak); sendb(8'h33, ak); bstop;
    chk(c_cfg == s0+3 && l_idx == 3'd2 && l_data == 8'h33, "R5 index", l_idx, 2);

    // R3: foreign address not acknowledged, line stays released
    any_oe = 1'b0;
    bstart; sendb(8'hB6, ak); bstop;
    chk(!ak && !any_oe, "R3 foreign addr", any_oe, 0);

    // R8: read with wrap, then NACK end
    bstart; sendb(AR_OLD, ak);
    chk(ak, "R3 read addr ack", ak, 1);
    recvb(1, rb); chk(rb == 8'h96, "R8 byte0", rb, 8'h96);
    recvb(1, rb); chk(rb == 8'hA5, "R8 byte1", rb, 8'hA5);
    recvb(1, rb); chk(rb == 8'h3C, "R8 byte2", rb, 8'h3C);
    recvb(0, rb); chk(rb == 8'h96, "R8 wrap", rb, 8'h96);
    hw(4); chk(sda_oe == 0, "R8 nack release", sda_oe, 0);
    bstop;
    bstart; sendb(AR_OLD, ak); recvb(0, rb); bstop;
    chk(rb == 8'h96, "R8 restart index", rb, 8'h96);

    // R2: pins change without reset keeps old address
    pins = 3'b111; hw(10);
    bstart; sendb(AW_OLD, ak); bstop;
    chk(ak, "R2 old addr kept", ak, 1);
    bstart; sendb(AW_NEW, ak); bstop;
    chk(!ak, "R2 new addr ignored", ak, 0);

    // R6: reset command re-latches
    s3 = c_rst;
    wframe(AW_OLD, 8'h00, 8'h00, ok);
    chk(ok && c_rst == s3+1, "R6 soft reset", c_rst, s3+1);
    bstart; sendb(AW_NEW, ak); bstop;
    chk(ak, "R6 new addr", ak, 1);
    bstart; sendb(AW_OLD, ak); bstop;
    chk(!ak, "R6 old addr dropped", ak, 0);

    // R7: general call reset
    pins = 3'b010; s3 = c_rst;
    bstart; sendb(8'h00, ak); sendb(8'h06, ok); bstop;
    chk(ak && ok && c_rst == s3+1, "R7 general call 06", c_rst, s3+1);
    bstart; sendb(AW_OLD, ak); bstop;
    chk(ak, "R7 relatch", ak, 1);
    s3 = c_rst;
    bstart; sendb(8'h00, ak); sendb(8'h07, ok); bstop;
    chk(ak && !ok && c_rst == s3, "R7 other byte", ok, 0);

    // R9: repeated start aborts a frame
    bstart; sendb(8'h3C, ak);
    bstart; sendb(AW_OLD, ok); bstop;
    chk(!ak && ok, "R9 restart after foreign", ok, 1);
    s0 = c_cfg;
    bstart; sendb(AW_OLD, ak); sendb(8'h01, ak); sendb(8'h77, ak);
    bstart; sendb(AR_OLD, ak); recvb(0, rb); bstop;
    chk(ak && rb == 8'h96 && c_cfg == s0+1, "R9 write then read", rb, 8'h96);
    chk(sda_oe == 0, "R10 idle released", sda_oe, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule